// File: doc/BRIEF.md
# Byte-Wide Host Register Bank with Indirect Pointer

This block is the host-facing register interface of a video processing core. A host reaches it through a chip select, separate read and write strobes, a 2-bit direct address and a byte data path. Four registers are addressed directly: a control register, a mode register, an address pointer and a data port. The data port opens a window onto twelve indirect byte locations, 0 to 11, selected by the pointer. The pointer moves forward by one after every data-port access and stops on the last location, so the host can stream a block of configuration bytes after loading a single start address.

The core sees the enable bit, the mode byte and all indirect bytes as plain outputs, and drives a frame-busy flag and a line count back in. While a frame is busy the mode register, the pointer and the indirect space are locked; the control register stays open at all times so processing can be stopped mid-frame. A reset sequencer keeps the register state cleared for two clock cycles after the external reset is released.

The sequencer has three named states. HELD is entered asynchronously whenever `rst_n` is low. The transition HELD to TAIL happens on the first clock edge with `rst_n` high. The transition TAIL to READY happens on the next edge. READY is left only through an asserted reset. Host accesses are accepted only in READY.

Top module: `hostreg_bank`

## Requirements
- R1: While `rst_n` is low and for the two clock cycles after it rises, every host access is ignored and `rdata` is 0. The enable bit, the mode byte, the pointer and all indirect bytes clear to 0.
- R2: Direct address 0 is the control register. A read returns {VERSION[3:0], 3'b000, enable}. A write loads only the enable bit, from `wdata[0]`. The register is accessible whether or not `frame_busy` is high.
- R3: When `frame_busy` is low, direct address 1 reads and writes the 8-bit mode byte, and `mode_q` shows it.
- R4: When `frame_busy` is low, a write to direct address 2 loads the pointer, and values above 11 load as 11. A read of address 2 returns the pointer, zero-extended, and does not move it.
- R5: When `frame_busy` is low, each read or write of direct address 3 accesses the location the pointer names, then advances the pointer by one.
- R6: The pointer stops at 11. Further data-port accesses leave it at 11 and keep accessing location 11.
- R7: Location 10 is read-only and returns the `line_count` input. A write there is discarded but still advances the pointer.
- R8: While `frame_busy` is high, writes to addresses 1, 2 and 3 change nothing, the pointer does not move, and reads of those addresses return 0.
- R9: `run_en` equals the enable bit. `cfg_bytes[8*k+7:8*k]` holds indirect location k, and the byte for location 10 is always 0.
- R10: With `sel` low, or with neither strobe high, no register changes and `rdata` is 0. If `rd` and `wr` are both high, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers and host accesses |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| sel | input | 1 | Chip select for a host access |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Direct address: 0 control, 1 mode, 2 pointer, 3 data port |
| wdata | input | 8 | Write data |
| frame_busy | input | 1 | High while the core processes a frame; locks addresses 1 to 3 |
| line_count | input | 8 | Line count from the core, read at location 10 |
| rdata | output | 8 | Combinational read data; 0 when no read is accepted |
| run_en | output | 1 | Processing enable bit |
| mode_q | output | 8 | Mode byte |
| cfg_bytes | output | 96 | Indirect locations 0 to 11, one byte each, location k at bits 8k+7:8k |

## Verification
Read data is combinational. The bench samples `rdata` one time step after it raises the strobes, which is still before the clock edge that advances the pointer. A write, a pointer load or a pointer step is visible on the outputs after the next rising edge, so the bench checks it from the following falling edge onward. Reset release is the one case with a longer delay: a write held across the two edges that follow release must have no effect, and the same write must take effect on the third edge. The bench sweeps all 256 mode values and all 256 pointer loads, and it predicts every stored byte, clamped pointer and saturated step with its own arithmetic.

// File: rtl/hr_pkg.sv
package hr_pkg;
    localparam int DW      = 8;
    localparam int NUM_IND = 12;
    localparam int LC_LOC  = 10;
    localparam int PW      = $clog2(NUM_IND);
    localparam logic [PW-1:0] PTR_LAST = PW'(NUM_IND - 1);

    typedef enum logic [1:0] {
        DA_CTRL = 2'd0,
        DA_MODE = 2'd1,
        DA_PTR  = 2'd2,
        DA_DATA = 2'd3
    } dir_addr_e;

    typedef enum logic [1:0] {
        RS_HELD  = 2'd0,
        RS_TAIL  = 2'd1,
        RS_READY = 2'd2
    } rst_state_e;
endpackage

// File: rtl/hr_reset_seq.sv
module hr_reset_seq
    import hr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    rst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_HELD:  state_d = RS_TAIL;
            RS_TAIL:  state_d = RS_READY;
            RS_READY: state_d = RS_READY;
            default:  state_d = RS_HELD;
        endcase
    end

    always_comb ready = (state_q == RS_READY);

    // R1: reset forces the held state
    assert_held_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> state_q == RS_HELD);
    // R1: ready only follows the tail cycle
    assert_tail_before_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(state_q) == RS_TAIL);
endmodule

// File: rtl/hr_pointer.sv
module hr_pointer
    import hr_pkg::*;
(
    input  logic          clk,
    input  logic          ready,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    logic [PW-1:0] clamped;

    always_comb clamped = (load_val > DW'(PTR_LAST)) ? PTR_LAST : load_val[PW-1:0];

    always_ff @(posedge clk) begin
        if (!ready)                       ptr <= '0;
        else if (load)                    ptr <= clamped;
        else if (step && ptr != PTR_LAST) ptr <= ptr + PW'(1);
    end

    // R6: pointer never leaves the indirect space
    assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!ready)
        ptr <= PTR_LAST);
    // R5: a step below the last location advances by one
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!ready)
        step && !load && ptr != PTR_LAST |=> ptr == $past(ptr) + PW'(1));
    // R6: a step at the last location stays put
    assert_ptr_sat_R6: assert property (@(posedge clk) disable iff (!ready)
        step && !load && ptr == PTR_LAST |=> ptr == PTR_LAST);
endmodule

// File: rtl/hr_cfg_array.sv
module hr_cfg_array
    import hr_pkg::*;
(
    input  logic                  clk,
    input  logic                  ready,
    input  logic                  wr_en,
    input  logic [PW-1:0]         sel_loc,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rbyte,
    output logic [NUM_IND*DW-1:0] cfg_flat
);
    for (genvar k = 0; k < NUM_IND; k++) begin : g_loc
        if (k == LC_LOC) begin : g_ro
            assign cfg_flat[k*DW +: DW] = '0;
        end else begin : g_rw
            logic [DW-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (!ready)                          byte_q <= '0;
                else if (wr_en && sel_loc == PW'(k)) byte_q <= wdata;
            end
            assign cfg_flat[k*DW +: DW] = byte_q;
        end
    end

    always_comb rbyte = cfg_flat[sel_loc*DW +: DW];

    // R8: no write enable, no change in the indirect bytes
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!ready)
        !wr_en |=> $stable(cfg_flat));
endmodule

// File: rtl/hostreg_bank.sv
module hostreg_bank
    import hr_pkg::*;
#(
    parameter logic [3:0] VERSION = 4'h5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [1:0]            addr,
    input  logic [DW-1:0]         wdata,
    input  logic                  frame_busy,
    input  logic [DW-1:0]         line_count,
    output logic [DW-1:0]         rdata,
    output logic                  run_en,
    output logic [DW-1:0]         mode_q,
    output logic [NUM_IND*DW-1:0] cfg_bytes
);
    logic          ready, acc, is_wr, is_rd, open;
    logic          ptr_load, ptr_step, cfg_wr;
    logic [PW-1:0] ptr;
    logic [DW-1:0] rbyte;
    dir_addr_e     da;

    hr_reset_seq u_rst (.clk(clk), .rst_n(rst_n), .ready(ready));

    always_comb begin
        da       = dir_addr_e'(addr);
        acc      = ready && sel && (rd || wr);
        is_wr    = acc && wr;
        is_rd    = acc && !wr;
        open     = !frame_busy;
        ptr_load = is_wr && da == DA_PTR && open;
        ptr_step = acc && da == DA_DATA && open;
        cfg_wr   = is_wr && da == DA_DATA && open && ptr != PW'(LC_LOC);
    end

    hr_pointer u_ptr (
        .clk(clk), .ready(ready), .load(ptr_load), .load_val(wdata),
        .step(ptr_step), .ptr(ptr)
    );

    hr_cfg_array u_cfg (
        .clk(clk), .ready(ready), .wr_en(cfg_wr), .sel_loc(ptr),
        .wdata(wdata), .rbyte(rbyte), .cfg_flat(cfg_bytes)
    );

    always_ff @(posedge clk) begin
        if (!ready) begin
            run_en <= 1'b0;
            mode_q <= '0;
        end else begin
            if (is_wr && da == DA_CTRL)         run_en <= wdata[0];
            if (is_wr && da == DA_MODE && open) mode_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (is_rd) begin
            unique case (da)
                DA_CTRL: rdata = {VERSION, 3'b000, run_en};
                DA_MODE: rdata = open ? mode_q : '0;
                DA_PTR:  rdata = open ? DW'(ptr) : '0;
                DA_DATA: rdata = !open ? '0 : (ptr == PW'(LC_LOC)) ? line_count : rbyte;
                default: rdata = '0;
            endcase
        end
    end

    // R2: control write lands even while busy
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!ready)
        sel && wr && addr == 2'd0 |=> run_en == $past(wdata[0]));
    // R8: mode and pointer frozen while busy
    assert_busy_mode_lock_R8: assert property (@(posedge clk) disable iff (!ready)
        frame_busy |=> $stable(mode_q));
    assert_busy_ptr_lock_R8: assert property (@(posedge clk) disable iff (!ready)
        frame_busy |=> $stable(ptr));
    // R10: no select, no change
    assert_nosel_hold_R10: assert property (@(posedge clk) disable iff (!ready)
        !sel |=> $stable(mode_q) && $stable(run_en) && $stable(ptr));
    // R1: nothing is read outside the ready state
    assert_no_read_in_reset_R1: assert property (@(posedge clk)
        !ready |-> rdata == '0);
endmodule

// File: tb/test_hostreg_bank.sv
module test_hostreg_bank;
    localparam int CLK_NS = 10;
    localparam logic [3:0] VER = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic        frame_busy = 1'b0;
    logic [7:0]  line_count = 8'hA5;
    logic [7:0]  rdata;
    logic        run_en;
    logic [7:0]  mode_q;
    logic [95:0] cfg_bytes;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    hostreg_bank #(.VERSION(VER)) i_hostreg_bank (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .frame_busy(frame_busy), .line_count(line_count),
        .rdata(rdata), .run_en(run_en), .mode_q(mode_q), .cfg_bytes(cfg_bytes)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        sel = 1; wr = 1; rd = 0; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic host_rd(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        sel = 1; rd = 1; wr = 0; addr = a;
        #1 v = rdata;
        @(negedge clk);
        sel = 0; rd = 0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (8) @(negedge clk);
        chk("R1 enable in reset", run_en, 0);
        chk("R1 mode in reset", mode_q, 0);
        chk("R1 cfg in reset", (cfg_bytes == '0) ? 1 : 0, 1);
        // release and hold a control write across the two tail edges
        @(negedge clk);
        rst_n = 1; sel = 1; wr = 1; addr = 2'd0; wdata = 8'h01;
        #1 chk("R1 rdata zero in tail", rdata, 0);
        @(negedge clk);
        @(negedge clk);
        chk("R1 write ignored after release", run_en, 0);
        @(negedge clk);
        sel = 0; wr = 0;
        chk("R1 write accepted once ready", run_en, 1);

        // R2 control register
        host_wr(2'd0, 8'hFE);
        chk("R9 run_en follows bit0", run_en, 0);
        host_rd(2'd0, v);
        chk("R2 ctrl read cleared", v, {VER, 4'h0});
        host_wr(2'd0, 8'hFF);
        host_rd(2'd0, v);
        chk("R2 ctrl read set", v, {VER, 4'h1});
        chk("R9 run_en set", run_en, 1);

        // R3 exhaustive mode sweep
        for (int m = 0; m < 256; m++) begin
            host_wr(2'd1, 8'(m));
            chk("R3 mode_q", mode_q, m);
            host_rd(2'd1, v);
            chk("R3 mode read", v, m);
        end

        // R4 exhaustive pointer load with clamp
        for (int p = 0; p < 256; p++) begin
            host_wr(2'd2, 8'(p));
            host_rd(2'd2, v);
            chk("R4 pointer load", v, (p > 11) ? 11 : p);
            host_rd(2'd2, v);
            chk("R4 pointer read does not move", v, (p > 11) ? 11 : p);
        end

        // R5 R6 R7 fill all locations by streaming writes
        host_wr(2'd2, 8'd0);
        for (int i = 0; i < 12; i++) begin
            host_wr(2'd3, pat(i));
            host_rd(2'd2, v);
            chk("R5 pointer after data write", v, (i + 1 > 11) ? 11 : i + 1);
        end
        for (int i = 0; i < 12; i++)
            chk("R9 cfg byte", cfg_bytes[8*i +: 8], (i == 10) ? 0 : pat(i));

        // R5 R7 R6 stream back with reads
        host_wr(2'd2, 8'd0);
        for (int i = 0; i < 12; i++) begin
            host_rd(2'd3, v);
            chk("R7 R5 data read", v, (i == 10) ? 8'hA5 : pat(i));
        end
        for (int i = 0; i < 3; i++) begin
            host_rd(2'd3, v);
            chk("R6 saturated read", v, pat(11));
        end
        host_rd(2'd2, v);
        chk("R6 pointer stays at 11", v, 11);
        host_wr(2'd3, 8'h77);
        chk("R6 write at saturation", cfg_bytes[88 +: 8], 8'h77);
        host_rd(2'd2, v);
        chk("R6 pointer still 11", v, 11);
        line_count = 8'h3C;
        host_wr(2'd2, 8'd10);
        host_rd(2'd3, v);
        chk("R7 line count read", v, 8'h3C);
        host_wr(2'd2, 8'd10);
        host_wr(2'd3, 8'h99);
        chk("R7 write discarded", cfg_bytes[80 +: 8], 0);
        host_rd(2'd2, v);
        chk("R7 write still advances", v, 11);

        // R8 busy lockout
        host_wr(2'd2, 8'd4);
        frame_busy = 1;
        host_wr(2'd1, 8'h3C);
        chk("R8 mode locked", mode_q, 8'hFF);
        host_wr(2'd2, 8'd1);
        host_wr(2'd3, 8'h11);
        chk("R8 cfg locked", cfg_bytes[32 +: 8], pat(4));
        host_rd(2'd1, v); chk("R8 mode read zero", v, 0);
        host_rd(2'd2, v); chk("R8 pointer read zero", v, 0);
        host_rd(2'd3, v); chk("R8 data read zero", v, 0);
        host_wr(2'd0, 8'h00);
        chk("R2 ctrl writable while busy", run_en, 0);
        host_rd(2'd0, v);
        chk("R2 ctrl readable while busy", v, {VER, 4'h0});
        frame_busy = 0;
        host_rd(2'd2, v);
        chk("R8 pointer did not move", v, 4);
        host_rd(2'd3, v);
        chk("R8 location kept", v, pat(4));

        // R10 no select, no strobe, both strobes
        @(negedge clk);
        sel = 0; wr = 1; rd = 1; addr = 2'd1; wdata = 8'h12;
        #1 chk("R10 rdata without select", rdata, 0);
        @(negedge clk);
        wr = 0; rd = 0;
        chk("R10 write without select", mode_q, 8'hFF);
        @(negedge clk);
        sel = 1; addr = 2'd0;
        #1 chk("R10 rdata without strobe", rdata, 0);
        @(negedge clk);
        wr = 1; rd = 1; addr = 2'd1; wdata = 8'h12;
        @(negedge clk);
        sel = 0; wr = 0; rd = 0;
        chk("R10 both strobes write", mode_q, 8'h12);

        // R1 reset mid-operation clears state
        @(negedge clk);
        rst_n = 0;
        repeat (8) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 mode cleared", mode_q, 0);
        chk("R1 cfg cleared", (cfg_bytes == '0) ? 1 : 0, 1);
        host_rd(2'd2, v);
        chk("R1 pointer cleared", v, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule